// File: doc/BRIEF.md
# ADC channel scan sequencer

This block steps an analog-to-digital converter through a programmable subset of up to 28 input channels so that no processor has to request each conversion. Configuration inputs carry a channel-enable bitmask, a two-bit run field, an 8-bit pause length between passes, four 5-bit negative-input selects for the even channels 0 to 6, and an input-buffer flag. The block issues one conversion request at a time. Each request carries the positive channel, the negative input and the buffer flag. When the converter answers with a done pulse and data, the block forwards the data with a channel tag on a valid/ready output that a DMA engine can drain.

A pass visits the enabled channels in ascending order. After the last result of a pass is accepted, the block raises a single interrupt pulse. While the run field stays active it begins the next pass, either at once or after a prescaled pause. Clearing the run field stops the scan cleanly. Any conversion already requested is allowed to complete, and its result is delivered, but no interrupt follows.

Top module: `adc_scan_seq`

## Requirements
- R1: Bit n of `cfg_chan_en` includes channel n in a pass. A channel whose bit is clear is never requested.
- R2: Within a pass, channels are requested in ascending order, once each, with `conv_req` high for exactly one cycle per request. Clear mask bits add no cycles: with `res_ready` high, successive requests are spaced by the converter latency plus two cycles, whatever the gap between the channel numbers.
- R3: The scan runs only while `cfg_start` equals 2'b11. A pass begins on the first cycle after `cfg_start` changes into 2'b11. The values 2'b00, 2'b01 and 2'b10 produce no requests.
- R4: `eos_irq` is high for one cycle, in the cycle after the last result of a pass is accepted. No interrupt is raised for the other conversions, and none is raised while a result is pending.
- R5: While `cfg_start` stays at 2'b11, the first request of the next pass comes 16*D+1 cycles after the interrupt cycle, where D is `cfg_delay`. For D=0, this is the very next cycle.
- R6: For channel 2k with k in 0..3, `conv_neg` equals `cfg_neg_sel[5k+4:5k]`, so channel 0 uses bits 4:0. Every other channel is requested with `conv_neg` equal to 0, which is the ground code.
- R7: `conv_buf` takes the value of `cfg_buf_en` sampled when a pass starts, and holds it for every request of that pass.
- R8: `res_valid` stays high, with `res_chan` and `res_data` stable, until `res_ready` is high. No new request is issued while a result is pending.
- R9: If the mask is all zero when a pass would start, `eos_irq` pulses in the next cycle, no request is issued and the block stays idle.
- R10: If `cfg_start` leaves 2'b11 during a pass, a conversion already requested still completes and its result is delivered. The block then goes idle with no interrupt and no further request.
- R11: A `conv_done` pulse that arrives while no conversion is outstanding is ignored and produces no result.
- R12: After reset, `conv_req`, `res_valid` and `eos_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 2 | Run field; 2'b11 runs the scan |
| cfg_chan_en | input | NUM_CH | Channel-enable bitmask |
| cfg_delay | input | DLY_W | Pause between passes, in 16-clock ticks |
| cfg_neg_sel | input | NUM_DIFF*NEG_W | Negative-input selects for channels 0, 2, 4, 6 |
| cfg_buf_en | input | 1 | Input-buffer flag, sampled at each pass start |
| conv_req | output | 1 | One-cycle conversion request |
| conv_pos | output | CH_W | Positive channel of the request |
| conv_neg | output | NEG_W | Negative input of the request |
| conv_buf | output | 1 | Buffer flag for the request |
| conv_done | input | 1 | Conversion-complete pulse |
| conv_data | input | DATA_W | Conversion result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Downstream accepts the result |
| res_chan | output | CH_W | Channel tag of the result |
| res_data | output | DATA_W | Result data |
| eos_irq | output | 1 | End-of-pass interrupt pulse |

## Verification
The bench uses a sparse mask that includes channel 27, the top bit. A priority search with an off-by-one error would drop that channel or revisit a lower one, and either fault shows up in the recorded request order and spacing. It covers an empty mask, the run encodings 01 and 10, and a stop placed just after a request. The empty-mask case catches a design that hangs waiting for results instead of pulsing the interrupt. The stop case catches a design that abandons the pending result or still interrupts. It toggles the buffer flag mid-pass, which catches a design that passes the flag straight through instead of holding it. It throttles the ready input at random, which catches a design that overwrites a pending result. It measures the restart gap for pause values 0 and 1, which catches a prescaler that is off by a cycle.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_SEND,
      ST_PAUSE
   } seq_state_e;
endpackage

// File: rtl/adc_seq_pick.sv
`timescale 1ns/1ps
// Lowest set mask bit at or above a floor index.
module adc_seq_pick #(
   parameter int NUM_CH = 28,
   parameter int IDX_W  = $clog2(NUM_CH),
   parameter int LO_W   = IDX_W + 1
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [LO_W-1:0]   lo,
   output logic              found,
   output logic [IDX_W-1:0]  idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i] && (i >= int'(lo))) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
// Pause counter: done when DLY ticks of 2**PS_LOG2 clocks have elapsed.
module adc_seq_timer #(
   parameter int DLY_W   = 8,
   parameter int PS_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DLY_W-1:0] dly,
   output logic             done
);
   localparam int CNT_W = DLY_W + PS_LOG2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;

   generate
      if (PS_LOG2 > 0) begin : g_prescaled
         assign target = {dly, {PS_LOG2{1'b0}}};
      end else begin : g_direct
         assign target = dly;
      end
   endgenerate

   assign done = (cnt_q == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (!done)  cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq #(
   parameter int NUM_CH   = 28,
   parameter int DATA_W   = 16,
   parameter int NEG_W    = 5,
   parameter int NUM_DIFF = 4,
   parameter int DLY_W    = 8,
   parameter int PS_LOG2  = 4,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int LO_W    = CH_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                cfg_start,
   input  logic [NUM_CH-1:0]         cfg_chan_en,
   input  logic [DLY_W-1:0]          cfg_delay,
   input  logic [NUM_DIFF*NEG_W-1:0] cfg_neg_sel,
   input  logic                      cfg_buf_en,
   output logic                      conv_req,
   output logic [CH_W-1:0]           conv_pos,
   output logic [NEG_W-1:0]          conv_neg,
   output logic                      conv_buf,
   input  logic                      conv_done,
   input  logic [DATA_W-1:0]         conv_data,
   output logic                      res_valid,
   input  logic                      res_ready,
   output logic [CH_W-1:0]           res_chan,
   output logic [DATA_W-1:0]         res_data,
   output logic                      eos_irq
);
   import adc_seq_pkg::*;

   generate
      if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_ch
         $error("NUM_CH must lie in 2..32");
      end
      if (2 * NUM_DIFF > NUM_CH) begin : g_bad_diff
         $error("differential channels exceed channel count");
      end
      if (DLY_W < 1 || PS_LOG2 < 0) begin : g_bad_dly
         $error("bad pause timer geometry");
      end
   endgenerate

   seq_state_e          state_q, state_d;
   logic [CH_W-1:0]     cur_q, cur_d;
   logic                buf_q, buf_d;
   logic [DATA_W-1:0]   data_q, data_d;
   logic                irq_q, irq_d;
   logic                run_q;
   logic                run;
   logic [LO_W-1:0]     floor_idx;
   logic                nxt_found;
   logic [CH_W-1:0]     nxt_idx;
   logic                pause_done;
   logic [NEG_W-1:0]    neg_field [NUM_DIFF];
   logic [NEG_W-1:0]    neg_sel;

   assign run = (cfg_start == 2'b11);

   // Search floor: one above the current channel while stepping, else zero.
   assign floor_idx = (state_q == ST_SEND) ? (LO_W'(cur_q) + LO_W'(1)) : '0;

   adc_seq_pick #(.NUM_CH(NUM_CH), .IDX_W(CH_W), .LO_W(LO_W)) u_pick (
      .mask  (cfg_chan_en),
      .lo    (floor_idx),
      .found (nxt_found),
      .idx   (nxt_idx)
   );

   adc_seq_timer #(.DLY_W(DLY_W), .PS_LOG2(PS_LOG2)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == ST_PAUSE),
      .dly   (cfg_delay),
      .done  (pause_done)
   );

   genvar k;
   generate
      for (k = 0; k < NUM_DIFF; k++) begin : g_neg
         assign neg_field[k] = cfg_neg_sel[k*NEG_W +: NEG_W];
      end
   endgenerate

   always_comb begin
      neg_sel = '0;
      for (int j = 0; j < NUM_DIFF; j++) begin
         if (cur_q == CH_W'(2 * j)) neg_sel = neg_field[j];
      end
   end

   always_comb begin
      state_d = state_q;
      cur_d   = cur_q;
      buf_d   = buf_q;
      data_d  = data_q;
      irq_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (run && !run_q) begin
               if (nxt_found) begin
                  state_d = ST_ISSUE;
                  cur_d   = nxt_idx;
                  buf_d   = cfg_buf_en;
               end else begin
                  irq_d = 1'b1;
               end
            end
         end
         ST_ISSUE: state_d = run ? ST_WAIT : ST_IDLE;
         ST_WAIT: begin
            if (conv_done) begin
               data_d  = conv_data;
               state_d = ST_SEND;
            end
         end
         ST_SEND: begin
            if (res_ready) begin
               if (!run) begin
                  state_d = ST_IDLE;
               end else if (nxt_found) begin
                  state_d = ST_ISSUE;
                  cur_d   = nxt_idx;
               end else begin
                  state_d = ST_PAUSE;
                  irq_d   = 1'b1;
               end
            end
         end
         ST_PAUSE: begin
            if (!run) begin
               state_d = ST_IDLE;
            end else if (pause_done) begin
               if (nxt_found) begin
                  state_d = ST_ISSUE;
                  cur_d   = nxt_idx;
                  buf_d   = cfg_buf_en;
               end else begin
                  state_d = ST_IDLE;
                  irq_d   = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         buf_q   <= 1'b0;
         data_q  <= '0;
         irq_q   <= 1'b0;
         run_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cur_q   <= cur_d;
         buf_q   <= buf_d;
         data_q  <= data_d;
         irq_q   <= irq_d;
         run_q   <= run;
      end
   end

   assign conv_req  = (state_q == ST_ISSUE) && run;
   assign conv_pos  = cur_q;
   assign conv_neg  = neg_sel;
   assign conv_buf  = buf_q;
   assign res_valid = (state_q == ST_SEND);
   assign res_chan  = cur_q;
   assign res_data  = data_q;
   assign eos_irq   = irq_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
`timescale 1ns/1ps
module adc_scan_seq_chk #(
   parameter int CH_W     = 5,
   parameter int DATA_W   = 16,
   parameter int NEG_W    = 5,
   parameter int NUM_DIFF = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cfg_start,
   input logic              conv_req,
   input logic [CH_W-1:0]   conv_pos,
   input logic [NEG_W-1:0]  conv_neg,
   input logic              res_valid,
   input logic              res_ready,
   input logic [CH_W-1:0]   res_chan,
   input logic [DATA_W-1:0] res_data,
   input logic              eos_irq
);
   AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req); // R2

   AST_STOPPED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_start != 2'b11) |-> !conv_req); // R3

   AST_IRQ_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      eos_irq |-> !res_valid); // R4

   AST_SINGLE_ENDED_GND: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && (conv_pos[0] || (conv_pos >= CH_W'(2 * NUM_DIFF)))) |-> (conv_neg == '0)); // R6

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan))); // R8

   AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !conv_req); // R8
endmodule

bind adc_scan_seq adc_scan_seq_chk #(
   .CH_W(CH_W), .DATA_W(DATA_W), .NEG_W(NEG_W), .NUM_DIFF(NUM_DIFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
   .conv_req(conv_req), .conv_pos(conv_pos), .conv_neg(conv_neg),
   .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan),
   .res_data(res_data), .eos_irq(eos_irq)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
   localparam int NUM_CH = 28;
   localparam int ADC_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_start = 2'b00;
   logic [27:0] cfg_chan_en = '0;
   logic [7:0]  cfg_delay = '0;
   logic [19:0] cfg_neg_sel = '0;
   logic        cfg_buf_en = 1'b0;
   logic        conv_req;
   logic [4:0]  conv_pos;
   logic [4:0]  conv_neg;
   logic        conv_buf;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = '0;
   logic        res_valid;
   logic        res_ready = 1'b1;
   logic [4:0]  res_chan;
   logic [15:0] res_data;
   logic        eos_irq;

   always #2 clk = ~clk;   // 250 MHz

   adc_scan_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_chan_en(cfg_chan_en),
      .cfg_delay(cfg_delay), .cfg_neg_sel(cfg_neg_sel), .cfg_buf_en(cfg_buf_en),
      .conv_req(conv_req), .conv_pos(conv_pos), .conv_neg(conv_neg), .conv_buf(conv_buf),
      .conv_done(conv_done), .conv_data(conv_data), .res_valid(res_valid),
      .res_ready(res_ready), .res_chan(res_chan), .res_data(res_data), .eos_irq(eos_irq)
   );

   int vectors = 0;
   int fails = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_phase = 0;   // 0 idle, 1 request, 2 await, 3 present, 4 pause
   int m_ch = 0;
   int m_cnt = 0;
   bit m_buf = 0, m_irq = 0, m_prev_run = 0, m_irq_n;
   int m_rdata = 0;
   int cyc = 0;
   bit m_run;
   int m_nx;

   function automatic int first_from(input int lo);
      for (int i = lo; i < NUM_CH; i++) if (cfg_chan_en[i]) return i;
      return -1;
   endfunction

   function automatic int neg_of(input int ch);
      if (ch < 8 && (ch % 2) == 0) return int'((cfg_neg_sel >> ((ch / 2) * 5)) & 20'h1F);
      return 0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_phase = 0; m_prev_run = 0; m_irq = 0; m_cnt = 0;
      end else begin
         m_run = (cfg_start == 2'b11);
         m_irq_n = 0;
         case (m_phase)
            0: if (m_run && !m_prev_run) begin
                  m_nx = first_from(0);
                  if (m_nx < 0) m_irq_n = 1;
                  else begin m_phase = 1; m_ch = m_nx; m_buf = cfg_buf_en; end
               end
            1: m_phase = m_run ? 2 : 0;
            2: if (conv_done) begin m_rdata = int'(conv_data); m_phase = 3; end
            3: if (res_ready) begin
                  if (!m_run) m_phase = 0;
                  else begin
                     m_nx = first_from(m_ch + 1);
                     if (m_nx >= 0) begin m_ch = m_nx; m_phase = 1; end
                     else begin m_phase = 4; m_cnt = 0; m_irq_n = 1; end
                  end
               end
            4: if (!m_run) m_phase = 0;
               else if (m_cnt == int'(cfg_delay) * 16) begin
                  m_nx = first_from(0);
                  if (m_nx >= 0) begin m_phase = 1; m_ch = m_nx; m_buf = cfg_buf_en; end
                  else begin m_irq_n = 1; m_phase = 0; end
               end else m_cnt++;
            default: m_phase = 0;
         endcase
         m_prev_run = m_run;
         m_irq = m_irq_n;
      end
   end

   // ---------------- comparison, converter model, observation ----------------
   int adc_cnt = -1;
   logic [4:0] conv_num = '0;
   logic [15:0] adc_word = '0;
   bit inject_done = 0;
   bit rand_ready = 0;
   logic [15:0] lfsr = 16'hACE1;
   int ch_log[$];
   int buf_log[$];
   int req_cyc[$];
   int irq_cnt = 0, irq_cyc = 0, last_gap = -1, res_cnt = 0, valid_cnt = 0, res_at_irq = -1;
   bit gap_armed = 0;
   bit e_req, e_valid;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         e_req = (m_phase == 1) && (cfg_start == 2'b11);
         e_valid = (m_phase == 3);
         chk(conv_req === e_req, "R1 R3 conv_req", int'(conv_req), int'(e_req));
         if (e_req && conv_req) begin
            chk(int'(conv_pos) == m_ch, "R2 channel order", int'(conv_pos), m_ch);
            chk(int'(conv_neg) == neg_of(m_ch), "R6 negative input", int'(conv_neg), neg_of(m_ch));
            chk(conv_buf == m_buf, "R7 buffer flag", int'(conv_buf), int'(m_buf));
         end
         chk(res_valid === e_valid, "R8 R11 res_valid", int'(res_valid), int'(e_valid));
         if (e_valid && res_valid) begin
            chk(int'(res_chan) == m_ch, "R8 result tag", int'(res_chan), m_ch);
            chk(int'(res_data) == m_rdata, "R8 result data", int'(res_data), m_rdata);
         end
         chk(eos_irq === m_irq, "R4 R9 eos_irq", int'(eos_irq), int'(m_irq));

         if (conv_req) begin
            ch_log.push_back(int'(conv_pos));
            buf_log.push_back(int'(conv_buf));
            req_cyc.push_back(cyc);
            if (gap_armed) begin last_gap = cyc - irq_cyc; gap_armed = 0; end
         end
         if (eos_irq) begin irq_cnt++; irq_cyc = cyc; gap_armed = 1; res_at_irq = res_cnt; end
         if (res_valid) valid_cnt++;
         if (res_valid && res_ready) res_cnt++;
      end
      // converter responder with fixed latency
      conv_done = 1'b0;
      if (adc_cnt > 0) adc_cnt--;
      if (adc_cnt == 0) begin conv_done = 1'b1; conv_data = adc_word; adc_cnt = -1; end
      if (rst_n && conv_req) begin
         adc_word = {conv_buf, conv_pos, conv_neg, conv_num};
         conv_num = conv_num + 5'd1;
         adc_cnt = ADC_LAT;
      end
      if (inject_done) begin conv_done = 1'b1; conv_data = 16'hBEEF; inject_done = 0; end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      res_ready = rand_ready ? lfsr[0] : 1'b1;
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic clear_logs();
      ch_log.delete(); buf_log.delete(); req_cyc.delete();
      irq_cnt = 0; res_cnt = 0; valid_cnt = 0; last_gap = -1; gap_armed = 0; res_at_irq = -1;
   endtask

   task automatic wait_irqs(input int n);
      while (irq_cnt < n) @(posedge clk);
      step(1);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int r0, v0;
      step(5);
      rst_n = 1'b1;
      step(1);
      // R12 reset state
      chk(conv_req == 0 && res_valid == 0 && eos_irq == 0, "R12 reset outputs",
          int'({conv_req, res_valid, eos_irq}), 0);

      // Sparse mask including the top channel, pause of one tick
      cfg_chan_en = (28'd1 << 0) | (28'd1 << 3) | (28'd1 << 4) | (28'd1 << 9) | (28'd1 << 27);
      cfg_neg_sel = {5'h1F, 5'h0A, 5'h03, 5'h11};
      cfg_buf_en = 1'b1;
      cfg_delay = 8'd1;
      clear_logs();
      cfg_start = 2'b11;
      wait_irqs(1);
      while (ch_log.size() < 6) @(posedge clk);
      step(1);
      cfg_start = 2'b00;
      step(40);
      chk(ch_log.size() >= 5 && ch_log[0] == 0 && ch_log[1] == 3 && ch_log[2] == 4,
          "R1 R2 first channels", ch_log.size() > 2 ? ch_log[2] : -1, 4);
      chk(ch_log.size() >= 5 && ch_log[3] == 9 && ch_log[4] == 27, "R1 R2 top channel",
          ch_log.size() > 4 ? ch_log[4] : -1, 27);
      chk(req_cyc.size() >= 5 && req_cyc[4] - req_cyc[3] == ADC_LAT + 2, "R2 skip costs no cycles",
          req_cyc.size() >= 5 ? req_cyc[4] - req_cyc[3] : -1, ADC_LAT + 2);
      chk(res_at_irq == 5 && irq_cnt == 1, "R4 one interrupt per pass", res_at_irq, 5);
      chk(last_gap == 17, "R5 restart after one tick", last_gap, 17);

      // Non-run encodings
      clear_logs();
      cfg_start = 2'b01; step(30);
      cfg_start = 2'b10; step(30);
      chk(ch_log.size() == 0, "R3 no requests for 01/10", ch_log.size(), 0);
      cfg_start = 2'b00; step(5);

      // Empty mask
      clear_logs();
      cfg_chan_en = '0;
      cfg_start = 2'b11; step(20);
      chk(irq_cnt == 1 && ch_log.size() == 0, "R9 empty mask interrupt", irq_cnt, 1);
      cfg_start = 2'b00; step(5);

      // Zero pause, throttled ready, buffer flag flipped mid-pass
      clear_logs();
      cfg_chan_en = (28'd1 << 1) | (28'd1 << 2) | (28'd1 << 6);
      cfg_delay = 8'd0;
      cfg_buf_en = 1'b0;
      rand_ready = 1'b1;
      cfg_start = 2'b11;
      while (ch_log.size() < 1) @(posedge clk);
      step(1);
      cfg_buf_en = 1'b1;
      wait_irqs(3);
      cfg_start = 2'b00;
      step(40);
      rand_ready = 1'b0;
      chk(buf_log.size() >= 4 && buf_log[2] == 0, "R7 flag held in pass", buf_log.size() > 2 ? buf_log[2] : -1, 0);
      chk(buf_log.size() >= 4 && buf_log[3] == 1, "R7 flag taken at next pass", buf_log.size() > 3 ? buf_log[3] : -1, 1);
      chk(last_gap == 1, "R5 immediate restart", last_gap, 1);

      // Stop right after a request
      clear_logs();
      cfg_chan_en = '1;
      cfg_start = 2'b11;
      while (ch_log.size() < 3) @(posedge clk);
      step(1);
      cfg_start = 2'b00;
      r0 = res_cnt;
      step(60);
      chk(res_cnt == 3 && r0 == 2, "R10 in-flight result delivered", res_cnt, 3);
      chk(irq_cnt == 0 && ch_log.size() == 3, "R10 no interrupt after stop", irq_cnt, 0);

      // Stray done while idle
      v0 = valid_cnt;
      inject_done = 1'b1;
      step(15);
      chk(valid_cnt == v0, "R11 stray done ignored", valid_cnt, v0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         vectors++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule